// File: doc/BRIEF.md
# Serial Column Parity Accumulator

This block builds an 8-bit column parity signature over a message. The message bits arrive one per accepted cycle, most significant bit of each byte first. The signature sits in a shift register that has a single XOR gate. Each accepted bit is XORed with the bit leaving the top cell, and the result enters the bottom cell as the register moves up one place. Once any whole number of bytes has gone in, the register holds the bitwise XOR of all of those bytes. No byte-wide XOR accumulator is needed for this.

A byte-wide path is also provided and is enabled by a parameter. It folds one whole byte into the same register per cycle. The fold is either an XOR, which gives the same column parity, or a modulo-256 add, which gives a plain checksum byte. An equality flag compares the current signature with a parity byte taken from the receive side. A synchronous clear starts a new message, and an active-low asynchronous reset sets the register to zero.

Top module: `colpar_top`

## Requirements
- R1: While rst_ni is low, sig_o is 8'h00, with no clock edge needed.
- R2: A clock edge with clr_i high loads 8'h00. This takes priority over bit_vld_i and byte_vld_i.
- R3: A clock edge with clr_i, bit_vld_i and byte_vld_i all low leaves sig_o unchanged.
- R4: A clock edge with bit_vld_i high and clr_i low loads {sig_o[6:0], bit_i ^ sig_o[7]}.
- R5: Starting from zero, after 8 accepted bits sig_o equals those 8 bits, with the first bit in sig_o[7].
- R6: Starting from zero, after any whole number of bytes sent MSB first, sig_o equals the XOR of those bytes. The 32-bit message 11010110101010010100011101101010 gives 8'b01010010.
- R7: A clock edge with byte_vld_i high, byte_add_i low (XOR fold), and clr_i and bit_vld_i low loads sig_o ^ byte_i.
- R8: A clock edge with byte_vld_i high, byte_add_i high (add fold), and clr_i and bit_vld_i low loads (sig_o + byte_i) mod 256. The carry out is dropped.
- R9: When bit_vld_i and byte_vld_i are both high, the serial shift of R4 applies and byte_i is ignored.
- R10: match_o is high exactly when sig_o equals ref_i. It follows ref_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the signature |
| bit_vld_i | input | 1 | Accept bit_i this cycle |
| bit_i | input | 1 | Serial message bit, MSB of each byte first |
| byte_vld_i | input | 1 | Fold byte_i this cycle |
| byte_i | input | 8 | Parallel message byte |
| byte_add_i | input | 1 | Fold select: 0 = XOR, 1 = modulo-256 add |
| ref_i | input | 8 | Received parity byte for comparison |
| sig_o | output | 8 | Current signature register |
| match_o | output | 1 | sig_o equals ref_i |

## Verification
The bench drives every stimulus just after a falling edge. Every register update (R2 to R9) is then due at the next rising edge, one cycle later, so the bench samples sig_o at the falling edge that follows. The R5 and R6 results are due one cycle after the 8th or the 32nd accepted bit, and the bench checks them at those points. The reset value (R1) and match_o (R10) have no register on their path, so they are sampled a short delay after the input changes, with no clock edge in between.

// File: rtl/colpar_pkg.sv
package colpar_pkg;
  localparam int unsigned SIG_W = 8;
  typedef logic [SIG_W-1:0] sig_t;
  typedef enum logic {
    FOLD_XOR = 1'b0,
    FOLD_ADD = 1'b1
  } fold_e;
endpackage

// File: rtl/colpar_shift.sv
module colpar_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic         bit_i,
  output logic [W-1:0] nxt_o
);
  // single feedback XOR: bit leaving the top cell folds into the incoming bit
  assign nxt_o = {cur_i[W-2:0], bit_i ^ cur_i[W-1]};
endmodule

// File: rtl/colpar_fold.sv
module colpar_fold
  import colpar_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] data_i,
  input  fold_e        mode_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] sum;
  assign sum = cur_i + data_i; // carry out dropped by width

  always_comb begin
    unique case (mode_i)
      FOLD_ADD: nxt_o = sum;
      default:  nxt_o = cur_i ^ data_i;
    endcase
  end
endmodule

// File: rtl/colpar_eq.sv
module colpar_eq #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  assign eq_o = ~|(a_i ^ b_i);
endmodule

// File: rtl/colpar_top.sv
module colpar_top
  import colpar_pkg::*;
#(
  parameter int unsigned W       = SIG_W,
  parameter bit          EN_BYTE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  input  logic         byte_vld_i,
  input  logic [W-1:0] byte_i,
  input  logic         byte_add_i,
  input  logic [W-1:0] ref_i,
  output logic [W-1:0] sig_o,
  output logic         match_o
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] acc_q;
  logic [W-1:0] shift_nxt;
  logic [W-1:0] fold_nxt;
  logic         fold_en;

  colpar_shift #(.W(W)) u_shift (
    .cur_i (acc_q),
    .bit_i (bit_i),
    .nxt_o (shift_nxt)
  );

  generate
    if (EN_BYTE) begin : g_fold
      colpar_fold #(.W(W)) u_fold (
        .cur_i  (acc_q),
        .data_i (byte_i),
        .mode_i (fold_e'(byte_add_i)),
        .nxt_o  (fold_nxt)
      );
      assign fold_en = byte_vld_i;
    end else begin : g_nofold
      assign fold_nxt = acc_q;
      assign fold_en  = 1'b0;
    end
  endgenerate

  // priority: clear, then serial bit, then parallel byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= ZERO;
    else if (clr_i)     acc_q <= ZERO;
    else if (bit_vld_i) acc_q <= shift_nxt;
    else if (fold_en)   acc_q <= fold_nxt;
  end

  colpar_eq #(.W(W)) u_eq (
    .a_i  (acc_q),
    .b_i  (ref_i),
    .eq_o (match_o)
  );

  assign sig_o = acc_q;

  // R2
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sig_o == ZERO));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !bit_vld_i && !byte_vld_i) |=> $stable(sig_o));

  // R4
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && bit_vld_i) |=>
      (sig_o[W-1:1] == $past(sig_o[W-2:0])) && (sig_o[0] == ($past(bit_i) ^ $past(sig_o[W-1]))));

  // R8
  add_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (EN_BYTE && !clr_i && !bit_vld_i && byte_vld_i && byte_add_i) |=>
      (sig_o == W'($past(sig_o) + $past(byte_i))));

  // R9
  bit_over_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && bit_vld_i && byte_vld_i) |=> (sig_o[W-1:1] == $past(sig_o[W-2:0])));

  // R10
  match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o == (sig_o == ref_i));
endmodule

// File: tb/colpar_top_bench.sv
module colpar_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       bvld = 1'b0;
  logic       bin = 1'b0;
  logic       yvld = 1'b0;
  logic [7:0] ybyte = 8'h00;
  logic       yadd = 1'b0;
  logic [7:0] refb = 8'h00;
  logic [7:0] sig;
  logic       match;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] msg;

  always #2 clk = ~clk;

  colpar_top u_colpar_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .clr_i      (clr),
    .bit_vld_i  (bvld),
    .bit_i      (bin),
    .byte_vld_i (yvld),
    .byte_i     (ybyte),
    .byte_add_i (yadd),
    .ref_i      (refb),
    .sig_o      (sig),
    .match_o    (match)
  );

  // {message, expected column parity}
  localparam logic [39:0] VEC [6] = '{
    {32'hD6A9476A, 8'h52},
    {32'h00000000, 8'h00},
    {32'hFFFFFFFF, 8'h00},
    {32'h12345678, 8'h08},
    {32'h80000001, 8'h81},
    {32'h01020408, 8'h0F}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    bvld = 1'b1; bin = b;
    @(negedge clk);
    bvld = 1'b0;
  endtask

  task automatic fold_byte(input logic [7:0] d, input logic add);
    yvld = 1'b1; ybyte = d; yadd = add;
    @(negedge clk);
    yvld = 1'b0;
  endtask

  task automatic clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 reset", sig, 8'h00);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      msg = VEC[i][39:8];
      clear();
      for (int k = 31; k >= 0; k--) begin
        shift_bit(msg[k]);
        if (k == 24) chk("R5 first byte", sig, msg[31:24]);
      end
      chk("R6 column parity", sig, VEC[i][7:0]);
      refb = VEC[i][7:0];
      #1;
      chk("R10 match high", {7'd0, match}, 8'h01);
    end

    // R3 idle hold
    @(negedge clk); @(negedge clk);
    chk("R3 hold", sig, 8'h0F);

    // R4 single steps
    clear();
    fold_byte(8'h80, 1'b0);
    shift_bit(1'b0);
    chk("R4 top bit feeds back", sig, 8'h01);
    clear();
    fold_byte(8'h80, 1'b0);
    shift_bit(1'b1);
    chk("R4 feedback cancels", sig, 8'h00);

    // R7 xor fold
    clear();
    fold_byte(8'h3C, 1'b0);
    fold_byte(8'h5A, 1'b0);
    chk("R7 xor fold", sig, 8'h66);

    // R8 add fold with wrap
    clear();
    fold_byte(8'hF0, 1'b1);
    fold_byte(8'h20, 1'b1);
    chk("R8 add wrap", sig, 8'h10);
    fold_byte(8'h05, 1'b1);
    chk("R8 add", sig, 8'h15);

    // R9 bit wins over byte
    yvld = 1'b1; ybyte = 8'hFF; yadd = 1'b0;
    shift_bit(1'b1);
    yvld = 1'b0;
    chk("R9 bit priority", sig, 8'h2B);

    // R10 mismatch, then match on same cycle
    refb = 8'h2A; #1;
    chk("R10 match low", {7'd0, match}, 8'h00);
    refb = 8'h2B; #1;
    chk("R10 match follows ref", {7'd0, match}, 8'h01);

    // R2 clear beats bit and byte
    @(negedge clk);
    clr = 1'b1; bvld = 1'b1; bin = 1'b1; yvld = 1'b1; ybyte = 8'h77;
    @(negedge clk);
    clr = 1'b0; bvld = 1'b0; yvld = 1'b0;
    chk("R2 clear priority", sig, 8'h00);

    // R1 async reset mid-message
    fold_byte(8'hA5, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async reset", sig, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule